// File: doc/BRIEF.md
# Indexed-Colour Palette Table

This block stores the colour palette of an indexed-colour display pipeline. It holds 256 entries, each a red, green and blue component of 4 bits. A host loads it through a narrow byte-wide register bus with two locations: a pointer register that selects an entry, and a data port. A triple of data-port writes fills the selected entry one component at a time.

The host first writes the pointer. Each complete triple of data writes then commits one entry and moves the pointer to the next entry, so a whole palette can be streamed after a single pointer write. The host can read entries back through the data port in the same component order. Separately, the pixel side presents an 8-bit pixel value every cycle and receives the matching 12-bit colour on the following cycle.

Top module: `palette_lut`

## Requirements
- R1: After reset the pointer is 0, the component phase is red, and `pix_rgb` is 0.
- R2: A write with `bus_addr`=0 loads `bus_wdata` into the pointer. A read with `bus_addr`=0 returns the pointer on `bus_rdata` in the same cycle.
- R3: Data-port writes (`bus_addr`=1) take red, then green, then blue. Each component is bits 7:4 of its byte, and bits 3:0 are ignored. `pix_rgb` packs red in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R4: An entry changes only on the blue write. Red and green writes leave both the table and the pointer unchanged.
- R5: A pointer write in the middle of a triple returns the phase to red. Components already held from the broken triple are not used.
- R6: After the blue write the pointer increases by one, wrapping from 255 to 0, and the phase returns to red.
- R7: A data-port read returns the current component of the pointed entry in bits 7:4, with bits 3:0 zero. Reads step through red, green and blue in the same way as writes, and the read of blue advances the pointer. If a read and a write occur in the same cycle, the write is performed and the read does not advance the sequence.
- R8: `pix_rgb` shows the entry selected by `pix_idx` one clock edge after `pix_idx` is applied, for any of the 256 values.
- R9: If a pixel lookup and a blue commit hit the same entry in the same cycle, the lookup returns the previous contents. The new contents appear from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | 1 | 0 = pointer register, 1 = data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 12 | Registered colour {R,G,B} |

## Verification
The blue-component commit from the host and the pixel lookup can hit the same table entry on the same clock edge. The bench provokes this by driving the blue write and a `pix_idx` equal to the pointed entry in one cycle, after a red and a green write that already differ from the stored colour. The scoreboard expects the old colour for that lookup and the new colour for a lookup one cycle later, so a design that forwards the new value, or one that shows a half-loaded entry, is reported.

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int BUS_W  = 8,
  parameter int COMP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [BUS_W-1:0]   pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int ENTRIES = 1 << BUS_W;
  localparam int RGB_W   = 3 * COMP_W;
  localparam logic [1:0] PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2;

  logic [RGB_W-1:0]  table_q [ENTRIES];
  logic [BUS_W-1:0]  idx_q;
  logic [1:0]        phase_q;
  logic [COMP_W-1:0] red_h, grn_h;
  logic [RGB_W-1:0]  cur_entry;
  logic [COMP_W-1:0] cur_comp;

  wire               wr_idx  = bus_wr && !bus_addr;
  wire               wr_dat  = bus_wr && bus_addr;
  wire               rd_dat  = bus_rd && !bus_wr && bus_addr;
  wire               step    = wr_dat || rd_dat;
  wire               commit  = wr_dat && (phase_q == PH_B);
  wire [COMP_W-1:0]  comp_in = bus_wdata[BUS_W-1 -: COMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_R;
      red_h   <= '0;
      grn_h   <= '0;
    end else if (wr_idx) begin
      idx_q   <= bus_wdata;
      phase_q <= PH_R;
    end else if (step) begin
      if (wr_dat && phase_q == PH_R) red_h <= comp_in;
      if (wr_dat && phase_q == PH_G) grn_h <= comp_in;
      if (phase_q == PH_B) begin
        phase_q <= PH_R;
        idx_q   <= idx_q + 1'b1;
      end else begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) table_q[idx_q] <= {red_h, grn_h, comp_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= table_q[pix_idx];
  end

  assign cur_entry = table_q[idx_q];

  always_comb begin
    case (phase_q)
      PH_R:    cur_comp = cur_entry[RGB_W-1 -: COMP_W];
      PH_G:    cur_comp = cur_entry[2*COMP_W-1 -: COMP_W];
      default: cur_comp = cur_entry[COMP_W-1:0];
    endcase
  end

  assign bus_rdata = bus_addr ? {cur_comp, {(BUS_W-COMP_W){1'b0}}} : idx_q;
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] idx_q,
  input logic [1:0]       phase_q
);
  p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr |=> idx_q == $past(bus_wdata));

  p_phase_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr |=> phase_q == 2'd0);

  p_blue_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr && phase_q == 2'd2 |=> idx_q == $past(idx_q) + 1'b1 && phase_q == 2'd0);

  p_hold_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr && phase_q != 2'd2 |=> $stable(idx_q) && phase_q == $past(phase_q) + 2'd1);

  p_read_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr && phase_q == 2'd2 |=> idx_q == $past(idx_q) + 1'b1 && phase_q == 2'd0);
endmodule

bind palette_lut palette_lut_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .idx_q(idx_q), .phase_q(phase_q)
);

// File: tb/palette_lut_tb_top.sv
module palette_lut_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [7:0]  bus_wdata = 0, pix_idx = 0;
  logic [7:0]  bus_rdata;
  logic [11:0] pix_rgb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [11:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_lut dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic host_rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic look(input logic [7:0] i, input logic [11:0] exp, input string tag);
    @(negedge clk); pix_idx = i; exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  // scoreboard monitor: result of a lookup applied before edge N is visible after edge N
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [11:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(pix_rgb == e, t, pix_rgb, e);
    end
  end

  function automatic logic [11:0] fill_val(input int i);
    return {i[3:0], ~i[3:0], i[7:4]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk); bus_addr = 0; #1;
    chk(bus_rdata == 8'h00, "R1 pointer", bus_rdata, 0);
    chk(pix_rgb == 12'h000, "R1 pix_rgb", pix_rgb, 0);

    // R2 pointer load and readback
    host_wr(0, 8'h05);
    host_rd(0, 8'h05, "R2 pointer readback");

    // R3 component order, low nibble ignored; R6 advance
    host_wr(1, 8'hA7); host_wr(1, 8'h5F); host_wr(1, 8'h31);
    host_rd(0, 8'h06, "R6 pointer advance");
    look(8'h05, 12'hA53, "R3 entry 5");

    // R4 partial triple invisible; R9 collision returns old
    host_wr(0, 8'h05);
    host_wr(1, 8'h10); host_wr(1, 8'h20);
    host_rd(0, 8'h05, "R4 pointer held mid-triple");
    look(8'h05, 12'hA53, "R4 no partial update");
    @(negedge clk); bus_wr = 1; bus_addr = 1; bus_wdata = 8'h30;
    pix_idx = 8'h05; exp_q.push_back(12'hA53); tag_q.push_back("R9 collision old value");
    @(posedge clk); #1 bus_wr = 0;
    look(8'h05, 12'h123, "R9 new value next cycle");

    // R5 pointer rewrite mid-triple
    host_wr(0, 8'h09); host_wr(1, 8'hF0);
    host_wr(0, 8'h09);
    host_wr(1, 8'h40); host_wr(1, 8'h50); host_wr(1, 8'h60);
    look(8'h09, 12'h456, "R5 phase restart");

    // R6 wrap
    host_wr(0, 8'hFF);
    host_wr(1, 8'h70); host_wr(1, 8'h80); host_wr(1, 8'h90);
    host_rd(0, 8'h00, "R6 pointer wrap");
    look(8'hFF, 12'h789, "R6 entry 255");

    // R7 readback sequence
    host_wr(0, 8'h05);
    host_rd(1, 8'h10, "R7 read red");
    host_rd(1, 8'h20, "R7 read green");
    host_rd(1, 8'h30, "R7 read blue");
    host_rd(0, 8'h06, "R7 read advances pointer");
    // R7 read and write together: write wins, read does not step
    host_wr(0, 8'h09);
    @(negedge clk); bus_wr = 1; bus_rd = 1; bus_addr = 1; bus_wdata = 8'hC0;
    @(posedge clk); #1 bus_wr = 0; bus_rd = 0;
    host_wr(1, 8'hD0); host_wr(1, 8'hE0);
    host_rd(0, 8'h0A, "R7 write wins over read");
    look(8'h09, 12'hCDE, "R7 collided write stored");

    // R8 full table stream and lookup
    host_wr(0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      logic [11:0] v; v = fill_val(i);
      host_wr(1, {v[11:8], 4'h3}); host_wr(1, {v[7:4], 4'hC}); host_wr(1, {v[3:0], 4'h9});
    end
    for (int i = 0; i < 256; i++) look(i[7:0], fill_val(i), "R8 lookup");
    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule